// File: doc/BRIEF.md
# Serial Alternate-Bit Inversion Encoder

This block sits on the transmit side of a narrow serial link and lowers the switching activity on the wire. Incoming bits are grouped into fixed-length words, counted from the first accepted bit after reset. While a word arrives, the block counts the transitions between neighbouring bits inside that word. When the count reaches half the word length, the word is sent with every second bit inverted, which turns dense toggling into long constant runs. Otherwise the word is sent unchanged.

The word is buffered until its count is complete. It is then replayed on the output during the arrival of the next word, one output bit for each accepted input bit, so the latency is one word. A flag travels with the replayed word and tells the receiver whether to undo the inversion. The flag is exported as a plain output. A word-start marker flags the first output bit of each word. The word length is the parameter `WORD_LEN` (default 8) and must be even.

Top module: `serial_ti_encoder`

## Requirements
- R1: After reset, `dout_valid`, `dout_flag` and `dout_first` are 0. No output bit is produced until one complete word has been accepted since reset. A reset in the middle of a word discards that partial word.
- R2: Transitions are counted only between adjacent bits of the same word. The last bit of one word and the first bit of the next never add a transition.
- R3: The flag of a word is 1 exactly when its transition count is at least `WORD_LEN/2`, which is 4 for the default. A word with 4 transitions gets flag 1. A word with 3 transitions gets flag 0.
- R4: In a word with flag 1, output bits at positions 2, 4, 6, ... are inverted. Positions are numbered from 1 at the first serial bit. Bits at odd positions pass unchanged.
- R5: A word with flag 0 is output bit-for-bit unchanged, in arrival order.
- R6: Output bit j of word k is driven on the clock edge that accepts input bit j of word k+1. It appears one cycle after that input bit is presented. `dout_first` is 1 only on output position 1.
- R7: `dout_flag` holds one value for all output bits of a word.
- R8: `dout_valid` is 1 only in the cycle after an input bit is accepted with `din_valid`. Idle input cycles produce no output and do not advance the word position.
- R9: The input word 11110000 (first bit leftmost) is output unchanged with flag 0. The word 10101010 is output as 11111111 with flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial input bit |
| din_valid | input | 1 | Input bit strobe |
| dout | output | 1 | Serial encoded bit |
| dout_valid | output | 1 | Encoded bit strobe |
| dout_flag | output | 1 | Inversion flag of the word being output |
| dout_first | output | 1 | Marks the first output bit of a word |

## Verification
The busiest edge accepts the last input bit of a word. On that same edge the block closes that word's count and decision, loads the word into the replay buffer, and emits the last bit of the previous word under the previous flag. The bench runs words back to back, so this overlap happens for every pair. It also places pairs where the flag changes between neighbours, such as a flagged word after an unflagged one. Each captured output word is then checked against its own expected bits, flag and marker. A boundary word whose count would cross the threshold only if the inter-word transition were counted checks that the counter clear and the handover do not interfere.

// File: rtl/serial_ti_encoder.sv
module serial_ti_encoder #(
  parameter int WORD_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic din_valid,
  output logic dout,
  output logic dout_valid,
  output logic dout_flag,
  output logic dout_first
);
  localparam int POS_W  = (WORD_LEN > 1) ? $clog2(WORD_LEN) : 1;
  localparam int CNT_W  = $clog2(WORD_LEN) + 1;
  localparam int THRESH = WORD_LEN / 2;

  logic [POS_W-1:0]    pos;
  logic [CNT_W-1:0]    tcount;
  logic                prev;
  logic [WORD_LEN-1:0] ibuf, obuf, word_now;
  logic                hflag, have_word;

  wire first_bit = (pos == '0);
  wire last_bit  = (pos == POS_W'(WORD_LEN - 1));
  wire step      = ~first_bit & (din ^ prev);
  wire [CNT_W-1:0] total = tcount + CNT_W'(step);
  wire decide    = (total >= CNT_W'(THRESH));
  wire flip      = hflag & pos[0];

  always_comb begin
    word_now      = ibuf;
    word_now[pos] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      tcount    <= '0;
      prev      <= 1'b0;
      ibuf      <= '0;
      obuf      <= '0;
      hflag     <= 1'b0;
      have_word <= 1'b0;
    end else if (din_valid) begin
      ibuf[pos] <= din;
      prev      <= din;
      tcount    <= first_bit ? '0 : total;
      pos       <= last_bit ? '0 : pos + POS_W'(1);
      if (last_bit) begin
        obuf      <= word_now;
        hflag     <= decide;
        have_word <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      dout_flag  <= 1'b0;
      dout_first <= 1'b0;
    end else begin
      dout_valid <= din_valid & have_word;
      if (din_valid & have_word) begin
        dout       <= obuf[pos] ^ flip;
        dout_flag  <= hflag;
        dout_first <= first_bit;
      end else begin
        dout_first <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_ti_encoder_chk.sv
module serial_ti_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic din_valid,
  input logic dout_valid,
  input logic dout_flag,
  input logic dout_first,
  input logic have_word
);
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !dout_valid && !dout_first);

  a_r1_no_output_before_word: assert property (@(posedge clk) disable iff (!rst_n)
    !have_word |=> !dout_valid);

  a_r8_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(din_valid));

  a_r6_first_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dout_first |-> dout_valid);

  a_r7_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_first) |-> $stable(dout_flag));
endmodule

bind serial_ti_encoder serial_ti_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .dout_valid(dout_valid),
  .dout_flag(dout_flag), .dout_first(dout_first), .have_word(have_word)
);

// File: tb/serial_ti_encoder_tb.sv
module serial_ti_encoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic dout, dout_valid, dout_flag, dout_first;

  int checks = 0;
  int errors = 0;

  logic [7:0] cap;
  int vcount;
  logic fl_all, fl_any, first_ok;

  always #5 clk = ~clk;

  serial_ti_encoder #(.WORD_LEN(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
    .dout(dout), .dout_valid(dout_valid), .dout_flag(dout_flag), .dout_first(dout_first)
  );

  // {input word (first bit = MSB), expected flag, expected output word}
  localparam logic [16:0] VEC [10] = '{
    {8'hF0, 1'b0, 8'hF0},   // R9 one transition
    {8'hAA, 1'b1, 8'hFF},   // R9 seven transitions
    {8'h00, 1'b0, 8'h00},   // R5 none
    {8'hCC, 1'b0, 8'hCC},   // R3 three transitions
    {8'h99, 1'b1, 8'hCC},   // R3 four transitions, ends in 1
    {8'h05, 1'b0, 8'h05},   // R2 boundary word, 3 inside
    {8'h55, 1'b1, 8'h00},   // R4
    {8'hFF, 1'b0, 8'hFF},   // R5
    {8'h66, 1'b1, 8'h33},   // R4 four transitions
    {8'h1F, 1'b0, 8'h1F}    // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w, input bit gap);
    cap = '0; vcount = 0; fl_all = 1'b1; fl_any = 1'b0; first_ok = 1'b1;
    for (int j = 0; j < 8; j++) begin
      din = w[7-j];
      din_valid = 1'b1;
      @(posedge clk); #1;
      if (dout_valid) begin
        vcount++;
        cap[7-j] = dout;
        fl_all &= dout_flag;
        fl_any |= dout_flag;
        if (dout_first != (j == 0)) first_ok = 1'b0;
      end
      if (gap && j == 3) begin
        din_valid = 1'b0;
        @(posedge clk); #1;
        check(!dout_valid, "R8 idle cycle gives no output", dout_valid, 0);
      end
    end
    din_valid = 1'b0;
  endtask

  task automatic check_word(input logic [16:0] v, input string tag);
    check(vcount == 8, {tag, " R6 bit count"}, vcount, 8);
    check(cap == v[7:0], {tag, " R4/R5 output word"}, cap, v[7:0]);
    check(fl_all == fl_any && fl_any == v[8], {tag, " R3/R7 flag"}, fl_any, v[8]);
    check(first_ok, {tag, " R6 word marker"}, first_ok, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!dout_valid && !dout_flag && !dout_first, "R1 reset outputs", {dout_valid, dout_flag, dout_first}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < 10; i++) begin
      send_word(VEC[i][16:9], (i % 3) == 1);
      if (i == 0) check(vcount == 0, "R1 no output during first word", vcount, 0);
      else check_word(VEC[i-1], $sformatf("word%0d", i - 1));
    end
    send_word(8'h00, 1'b0);
    check_word(VEC[9], "word9");

    // R1 reset mid-word discards the partial word
    for (int j = 0; j < 4; j++) begin
      din = 1'b1; din_valid = 1'b1;
      @(posedge clk); #1;
    end
    din_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check(!dout_valid && !dout_flag && !dout_first, "R1 mid-word reset outputs", {dout_valid, dout_flag, dout_first}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    send_word(8'hAA, 1'b0);
    check(vcount == 0, "R1 no stale word after reset", vcount, 0);
    send_word(8'hF0, 1'b1);
    check(cap == 8'hFF && fl_any && fl_all, "R9 10101010 encoded", cap, 8'hFF);
    send_word(8'h00, 1'b0);
    check(cap == 8'hF0 && !fl_any, "R9 11110000 unchanged", cap, 8'hF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule